// File: doc/BRIEF.md
# Bandwidth-Group Schedule Table Walker

This block walks a host-programmed schedule table, one entry per transmit cell slot. Each 8-bit entry names the bandwidth group that owns that slot. The table sits in a word RAM. Each 32-bit word holds four entries. The host fills the table through a plain write port. A size register sets how many words take part in the rotation.

Each pulse on the slot tick input makes the walker issue one entry, with a one-cycle valid strobe on the following cycle. Within a word the walker moves from the low byte to the high byte, then on to the next word. After the last byte of the last active word it returns to the start.

A new table size is held as pending and becomes the active size at the next natural wrap. There is one exception. If the new size ends below the word the walker is about to read, the next slot restarts at word 0 and the new size takes effect at once.

Top module: `sched_table_walker`

## Requirements
- R1: After reset the entry valid output is low, the size readback is zero, and the first slot tick issues byte 0 (bits 7..0) of table word 0.
- R2: Each cycle in which the slot tick input is high causes exactly one entry to be issued, with entry valid high in the next cycle only; entry valid is low in every cycle that does not follow a tick, including for back-to-back ticks.
- R3: Within a word, entries are issued from bits 7..0, then 15..8, then 23..16, then 31..24, after which the walker continues at byte 0 of the next word.
- R4: With an active size of N, the rotation covers words 0 to N (N+1 words); after byte 3 of word N the next entry is word 0, byte 0.
- R5: A programmed size of 0 gives a one-word table that repeats its four entries.
- R6: The size register keeps bits 10..0 of the written value; bits 31..11 of the readback are always zero, and bits 31..11 of a write are ignored.
- R7: A written size field above 1199 is stored and used as 1199, so the table never exceeds 1200 words (4800 entries).
- R8: A size write whose value is not below the word index of the next entry changes nothing in the current pass; the new size becomes active at the next wrap to word 0.
- R9: A size write whose value is below the word index of the next entry makes the next issued entry word 0, byte 0, with the new size active from then on.
- R10: A table write takes effect for slot ticks in later cycles; a tick in the same cycle as a write to the word being read issues the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table word write strobe |
| tbl_addr_i | input | 11 | Table word address; addresses of 1200 or more are ignored |
| tbl_wdata_i | input | 32 | Table word data, four entries, byte 0 issued first |
| size_we_i | input | 1 | Size register write strobe |
| size_wdata_i | input | 32 | Size register write data; bits 10..0 hold the last word index |
| size_rdata_o | output | 32 | Size register readback |
| slot_tick_i | input | 1 | One pulse per transmit cell slot |
| entry_o | output | 8 | Issued schedule entry (group number) |
| entry_valid_o | output | 1 | Entry strobe, one cycle per tick |

## Verification
The embedded assertions check the following on every cycle:
- the tick-to-valid relation;
- the byte stepping inside a word;
- the restart at word 0 after a forced or natural wrap;
- that the read index never passes the active end;
- that the stored size never exceeds the clamp limit or loses the written low bits.

Only the bench scenarios can show that the issued values are the right table bytes and that a size change is deferred to the wrap instead of applied early. The same holds for the clamped size of 2000 actually producing a full 1200-word rotation, and for a write racing a tick returning the old entry.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int DEF_ENTRY_W   = 8;
  localparam int DEF_LANES     = 4;
  localparam int DEF_MAX_WORDS = 1200;
  localparam int DEF_SIZE_W    = 11;
  localparam int DEF_REG_W     = 32;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_LANE,
    STEP_WORD,
    STEP_WRAP
  } step_e;
endpackage

// File: rtl/sched_table_ram.sv
module sched_table_ram #(
  parameter int ENTRY_W   = sched_pkg::DEF_ENTRY_W,
  parameter int LANES     = sched_pkg::DEF_LANES,
  parameter int MAX_WORDS = sched_pkg::DEF_MAX_WORDS,
  parameter int SIZE_W    = sched_pkg::DEF_SIZE_W,
  localparam int WORD_W   = ENTRY_W * LANES,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SIZE_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [SIZE_W-1:0]  raddr_i,
  input  logic [LANE_W-1:0]  rlane_i,
  output logic [ENTRY_W-1:0] rentry_o
);
  localparam logic [SIZE_W-1:0] DEPTH = SIZE_W'(MAX_WORDS);

  logic                 wr_ok;
  logic [ENTRY_W-1:0]   lane_rd [LANES];

  assign wr_ok = we_i && (waddr_i < DEPTH);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ENTRY_W-1:0] mem [MAX_WORDS];
    always_ff @(posedge clk_i) begin
      if (wr_ok) mem[waddr_i] <= wdata_i[g*ENTRY_W +: ENTRY_W];
    end
    assign lane_rd[g] = mem[raddr_i];
  end

  assign rentry_o = lane_rd[rlane_i];

  // read index must stay inside the physical table (R4)
  assert_read_in_table_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raddr_i < DEPTH);
endmodule

// File: rtl/sched_size_reg.sv
module sched_size_reg #(
  parameter int MAX_WORDS = sched_pkg::DEF_MAX_WORDS,
  parameter int SIZE_W    = sched_pkg::DEF_SIZE_W,
  parameter int REG_W     = sched_pkg::DEF_REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              upd_o,
  output logic [SIZE_W-1:0] upd_val_o
);
  localparam logic [SIZE_W-1:0] LAST_WORD = SIZE_W'(MAX_WORDS - 1);

  logic [SIZE_W-1:0] raw;
  logic [SIZE_W-1:0] clamped;
  logic [SIZE_W-1:0] size_q;

  assign raw     = wdata_i[SIZE_W-1:0];
  assign clamped = (raw > LAST_WORD) ? LAST_WORD : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   size_q <= '0;
    else if (we_i) size_q <= clamped;
  end

  assign rdata_o   = {{(REG_W-SIZE_W){1'b0}}, size_q};
  assign upd_o     = we_i;
  assign upd_val_o = clamped;

  assert_size_clamped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[SIZE_W-1:0] <= LAST_WORD);

  assert_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:SIZE_W] == '0);

  assert_low_bits_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wdata_i[SIZE_W-1:0] <= LAST_WORD))
      |=> rdata_o[SIZE_W-1:0] == $past(wdata_i[SIZE_W-1:0]));
endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import sched_pkg::*;
#(
  parameter int ENTRY_W  = DEF_ENTRY_W,
  parameter int LANES    = DEF_LANES,
  parameter int SIZE_W   = DEF_SIZE_W,
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               upd_i,
  input  logic [SIZE_W-1:0]  upd_val_i,
  input  logic [ENTRY_W-1:0] rentry_i,
  output logic [SIZE_W-1:0]  raddr_o,
  output logic [LANE_W-1:0]  rlane_o,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               valid_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [SIZE_W-1:0]  word_q, word_d;
  logic [LANE_W-1:0]  lane_q, lane_d;
  logic [SIZE_W-1:0]  act_q, pend_q;
  logic               force_q, force_d;
  logic [SIZE_W-1:0]  iss_word, eff_last;
  logic [LANE_W-1:0]  iss_lane;
  logic               at_end;
  logic               load_act;
  step_e              step;
  logic [ENTRY_W-1:0] entry_q;
  logic               valid_q;

  // a forced wrap reads word 0 against the pending end
  always_comb begin
    iss_word = force_q ? '0 : word_q;
    iss_lane = force_q ? '0 : lane_q;
    eff_last = force_q ? pend_q : act_q;
    at_end   = (iss_lane == LAST_LANE) && (iss_word == eff_last);
  end

  always_comb begin
    if (!tick_i)                     step = STEP_HOLD;
    else if (at_end)                 step = STEP_WRAP;
    else if (iss_lane == LAST_LANE)  step = STEP_WORD;
    else                             step = STEP_LANE;
  end

  always_comb begin
    word_d = word_q;
    lane_d = lane_q;
    unique case (step)
      STEP_LANE: begin word_d = iss_word;      lane_d = iss_lane + 1'b1; end
      STEP_WORD: begin word_d = iss_word + 1'b1; lane_d = '0; end
      STEP_WRAP: begin word_d = '0;            lane_d = '0; end
      default: ;
    endcase
  end

  assign load_act = tick_i && (force_q || at_end);

  always_comb begin
    if (upd_i)       force_d = (upd_val_i < word_d);
    else if (tick_i) force_d = 1'b0;
    else             force_d = force_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      lane_q  <= '0;
      act_q   <= '0;
      pend_q  <= '0;
      force_q <= 1'b0;
      entry_q <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      lane_q  <= lane_d;
      force_q <= force_d;
      if (load_act) act_q <= pend_q;
      if (upd_i)    pend_q <= upd_val_i;
      if (tick_i)   entry_q <= rentry_i;
      valid_q <= tick_i;
    end
  end

  assign raddr_o = iss_word;
  assign rlane_o = iss_lane;
  assign entry_o = entry_q;
  assign valid_o = valid_q;

  assert_valid_after_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> valid_o);

  assert_no_valid_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !valid_o);

  assert_lane_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !force_q && lane_q != LAST_LANE)
      |=> (lane_q == $past(lane_q) + 1'b1) && (word_q == $past(word_q)));

  assert_within_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_q |-> word_q <= act_q);

  assert_natural_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !force_q && lane_q == LAST_LANE && word_q == act_q)
      |=> (word_q == '0) && (lane_q == '0));

  assert_forced_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && force_q) |=> word_q == '0);
endmodule

// File: rtl/sched_table_walker.sv
module sched_table_walker
  import sched_pkg::*;
#(
  parameter int ENTRY_W   = DEF_ENTRY_W,
  parameter int LANES     = DEF_LANES,
  parameter int MAX_WORDS = DEF_MAX_WORDS,
  parameter int SIZE_W    = DEF_SIZE_W,
  parameter int REG_W     = DEF_REG_W,
  localparam int WORD_W   = ENTRY_W * LANES,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [SIZE_W-1:0]  tbl_addr_i,
  input  logic [WORD_W-1:0]  tbl_wdata_i,
  input  logic               size_we_i,
  input  logic [REG_W-1:0]   size_wdata_i,
  output logic [REG_W-1:0]   size_rdata_o,
  input  logic               slot_tick_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               entry_valid_o
);
  logic               upd;
  logic [SIZE_W-1:0]  upd_val;
  logic [SIZE_W-1:0]  raddr;
  logic [LANE_W-1:0]  rlane;
  logic [ENTRY_W-1:0] rentry;

  sched_size_reg #(
    .MAX_WORDS (MAX_WORDS),
    .SIZE_W    (SIZE_W),
    .REG_W     (REG_W)
  ) u_size (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (size_we_i),
    .wdata_i   (size_wdata_i),
    .rdata_o   (size_rdata_o),
    .upd_o     (upd),
    .upd_val_o (upd_val)
  );

  sched_table_ram #(
    .ENTRY_W   (ENTRY_W),
    .LANES     (LANES),
    .MAX_WORDS (MAX_WORDS),
    .SIZE_W    (SIZE_W)
  ) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tbl_we_i),
    .waddr_i  (tbl_addr_i),
    .wdata_i  (tbl_wdata_i),
    .raddr_i  (raddr),
    .rlane_i  (rlane),
    .rentry_o (rentry)
  );

  sched_walker #(
    .ENTRY_W (ENTRY_W),
    .LANES   (LANES),
    .SIZE_W  (SIZE_W)
  ) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (slot_tick_i),
    .upd_i     (upd),
    .upd_val_i (upd_val),
    .rentry_i  (rentry),
    .raddr_o   (raddr),
    .rlane_o   (rlane),
    .entry_o   (entry_o),
    .valid_o   (entry_valid_o)
  );
endmodule

// File: tb/sched_table_walker_tb_top.sv
`timescale 1ns/1ps
module sched_table_walker_tb_top;
  localparam int WORDS = 1200;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_we = 1'b0;
  logic [10:0] tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        size_we = 1'b0;
  logic [31:0] size_wdata = '0;
  logic [31:0] size_rdata;
  logic        tick = 1'b0;
  logic [7:0]  entry;
  logic        entry_valid;

  always #2.5 clk = ~clk;

  sched_table_walker dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .tbl_we_i      (tbl_we),
    .tbl_addr_i    (tbl_addr),
    .tbl_wdata_i   (tbl_wdata),
    .size_we_i     (size_we),
    .size_wdata_i  (size_wdata),
    .size_rdata_o  (size_rdata),
    .slot_tick_i   (tick),
    .entry_o       (entry),
    .entry_valid_o (entry_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] tbl [WORDS];
  int  mw = 0, ml = 0, mact = 0, mpend = 0;
  bit  mforce = 1'b0;

  function automatic logic [7:0] ent_of(int w, int l);
    return 8'(w * 13 + l * 61 + 5);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference stepping from the requirements
  task automatic model_issue(output int w, output int l);
    int last;
    w = mforce ? 0 : mw;
    l = mforce ? 0 : ml;
    last = mforce ? mpend : mact;
    if (mforce) mact = mpend;
    if (l == 3 && w == last) begin
      mact = mpend; mw = 0; ml = 0;
    end else if (l == 3) begin
      mw = w + 1; ml = 0;
    end else begin
      mw = w; ml = l + 1;
    end
    mforce = 1'b0;
  endtask

  task automatic burst(int n, string req);
    int w, l;
    logic [7:0] exp;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      model_issue(w, l);
      exp = tbl[w][l*8 +: 8];
      @(negedge clk);
      if (i == n - 1) tick = 1'b0;
      chk(entry_valid === 1'b1 && entry === exp, req, {entry_valid, entry}, {1'b1, exp});
    end
    @(negedge clk);
    chk(entry_valid === 1'b0, "R2", entry_valid, 0);
  endtask

  task automatic write_size(logic [31:0] v);
    int cl;
    @(negedge clk);
    size_we = 1'b1;
    size_wdata = v;
    @(negedge clk);
    size_we = 1'b0;
    cl = int'(v[10:0]);
    if (cl > 1199) cl = 1199;
    mpend = cl;
    mforce = (cl < mw);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(entry_valid === 1'b0, "R1", entry_valid, 0);
    chk(size_rdata === 32'h0, "R1", size_rdata, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(entry_valid === 1'b0, "R2", entry_valid, 0);
  endtask

  task automatic t_fill;
    @(negedge clk);
    tbl_we = 1'b1;
    for (int w = 0; w < WORDS; w++) begin
      tbl[w] = {ent_of(w, 3), ent_of(w, 2), ent_of(w, 1), ent_of(w, 0)};
      tbl_addr = 11'(w);
      tbl_wdata = tbl[w];
      @(negedge clk);
    end
    tbl_we = 1'b0;
  endtask

  task automatic t_size_zero;
    burst(1, "R1");
    burst(3, "R3");
    burst(8, "R5");
  endtask

  task automatic t_grow;
    write_size(32'd3);
    burst(24, "R8");
    burst(20, "R4");
  endtask

  task automatic t_reg;
    write_size(32'hFFFF_F805);
    chk(size_rdata === 32'd5, "R6", size_rdata, 5);
    write_size(32'd2000);
    chk(size_rdata === 32'd1199, "R7", size_rdata, 1199);
    burst(4 * WORDS + 40, "R7");
  endtask

  task automatic t_shrink;
    burst(300, "R4");
    write_size(32'd10);
    chk(size_rdata === 32'd10, "R6", size_rdata, 10);
    burst(1, "R9");
    burst(60, "R9");
  endtask

  task automatic t_race;
    int w, l;
    logic [7:0] exp;
    logic [31:0] nw;
    // at lane 0 of some word after burst alignment
    while (ml != 0) burst(1, "R3");
    w = mw;
    nw = ~tbl[w];
    @(negedge clk);
    tick = 1'b1;
    tbl_we = 1'b1;
    tbl_addr = 11'(w);
    tbl_wdata = nw;
    model_issue(w, l);
    exp = tbl[w][l*8 +: 8];
    @(negedge clk);
    tick = 1'b0;
    tbl_we = 1'b0;
    chk(entry_valid === 1'b1 && entry === exp, "R10", entry, exp);
    tbl[w] = nw;
    burst(3, "R10");
    burst(48, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_size_zero();
    t_grow();
    t_reg();
    t_shrink();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule